// File: doc/BRIEF.md
# Card Command Launch and Response Capture

This block is the command path of a memory-card host controller. Software programs a 6-bit command index, a 32-bit argument (as two 16-bit writes) and a command/data control word through a simple register port. The block sends the command to the card only while the card clock is enabled. It then checks the returned response length against the configured response type and packs the response bytes into a nine-entry, 16-bit response FIFO, which software drains one entry per read.

The card side is a request/response handshake. `cardReq` rises with a stable command index and argument and stays high until the card answers with `cardRspValid`, a byte count and up to sixteen bytes. When the answer completes, the block sets an end-of-command interrupt bit. It then flags either a good response or a response timeout. When a good response arrives and the control word enables data, it pulses `dataStart` to hand over to the data phase.

Top module: `mmcCmdPath`

## Requirements
- R1: After reset the status word (0x04) and the interrupt word (0x2C) read 0, `cardReq`, `dataStart` and `dataWrite` are low, and a response FIFO read (0x3C) returns 0.
- R2: A write to 0x00 with bit 1 set turns the card clock on, shown as status bit 8. A write with bit 0 set turns it off. When both bits are set in one write, the clock ends up off and nothing is launched.
- R3: The control word (0x10) keeps only the bits under mask 0x3DFF. The command index (0x30) keeps 6 bits and reads back with bit 6 set. The argument high half (0x34) and low half (0x38) each take the low 16 bits written and read back separately. The response timeout (0x14) keeps 7 bits and the read timeout (0x18) keeps 16 bits.
- R4: A control-word write launches at once when the clock is on, no handshake is outstanding and bit 10 (stop-transfer) of the written value is clear. `cardReq` is high from the next cycle, carrying the stored command index and argument, and stays high with those values stable until `cardRspValid` is seen.
- R5: A control-word write that cannot launch leaves a command pending. A later start-clock write launches it unless the stored control word has bit 10 set or the same write also stops the clock.
- R6: A launch attempt made while a handshake is outstanding is refused, including one in the same cycle as the completing response. The pending flag survives the refusal, so a later start-clock write launches the command with the index and control word current at that time.
- R7: The response type is control bits 1:0 as latched at launch: type 0 accepts any length, types 1 and 3 need at least 4 bytes, type 2 needs 16 bytes. A short response sets status bit 1. An acceptable one sets status bit 13. A launch clears both bits.
- R8: Every completed handshake sets interrupt bit 2, which stays set until reset.
- R9: On completion the FIFO is cleared and, for an acceptable response, entry i is loaded with card byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Bytes at or beyond the byte count read as zero.
- R10: Each read of 0x3C returns the next entry and advances the read position. After nine reads it returns 0. A completion rewinds the position to entry 0, even when it falls in the same cycle as a read.
- R11: When a good response completes with control bit 2 (data enable) set, `dataStart` is high for exactly the next cycle and `dataWrite` shows control bit 3. A short response or a clear bit 2 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the FIFO at 0x3C) |
| regAddr | input | 7 | Byte address of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, valid in the cycle of the read |
| cardReq | output | 1 | Command handshake outstanding |
| cardCmd | output | 6 | Command index of the outstanding command |
| cardArg | output | 32 | Argument of the outstanding command |
| cardRspValid | input | 1 | Card answer present this cycle |
| cardRspLen | input | 5 | Number of response bytes returned (0 to 16) |
| cardRspData | input | 128 | Response bytes, byte k in bits 8k+7:8k |
| dataStart | output | 1 | One-cycle pulse that starts the data phase |
| dataWrite | output | 1 | Direction of the data phase just started (1 = write) |

## Verification
Two pairs of functions can meet in one cycle here. The first pair is a launch attempt and the completion of the outstanding handshake. The bench raises `cardRspValid` in the same cycle as a start-clock write while a command is pending. It then judges that no new request appears and that the pending command goes out only on a later start-clock. The second pair is a FIFO read and a new response load. The bench reads 0x3C in the completion cycle and expects the following read to return the new entry 0. A behavioural model compares `cardReq` and `dataStart` against the design on every clock.

// File: rtl/mmcCmdPkg.sv
package mmcCmdPkg;
  localparam int REG_ADDR_W = 7;
  localparam int REG_DATA_W = 32;
  localparam int CMD_IDX_W  = 6;
  localparam int ARG_W      = 32;
  localparam int HALF_W     = 16;
  localparam int RSPTO_W    = 7;
  localparam int RDTO_W     = 16;

  localparam logic [REG_ADDR_W-1:0] OFF_CLKCTL  = 7'h00;
  localparam logic [REG_ADDR_W-1:0] OFF_STATUS  = 7'h04;
  localparam logic [REG_ADDR_W-1:0] OFF_CTRL    = 7'h10;
  localparam logic [REG_ADDR_W-1:0] OFF_RSPTO   = 7'h14;
  localparam logic [REG_ADDR_W-1:0] OFF_RDTO    = 7'h18;
  localparam logic [REG_ADDR_W-1:0] OFF_INTREQ  = 7'h2C;
  localparam logic [REG_ADDR_W-1:0] OFF_CMDIDX  = 7'h30;
  localparam logic [REG_ADDR_W-1:0] OFF_ARGHI   = 7'h34;
  localparam logic [REG_ADDR_W-1:0] OFF_ARGLO   = 7'h38;
  localparam logic [REG_ADDR_W-1:0] OFF_RSPFIFO = 7'h3C;

  localparam logic [REG_DATA_W-1:0] CTRL_MASK = 32'h0000_3DFF;
  localparam int CTRL_DATA_EN = 2;
  localparam int CTRL_WRITE   = 3;
  localparam int CTRL_STOP    = 10;
  localparam int CLK_STOP_BIT  = 0;
  localparam int CLK_START_BIT = 1;
  localparam int STAT_TOUT  = 1;
  localparam int STAT_CLKON = 8;
  localparam int STAT_RSPOK = 13;
  localparam int INT_ENDCMD = 2;
  localparam int CMD_READ_FLAG = 6;
  localparam int SHORT_RSP_BYTES = 4;

  typedef struct packed {
    logic loadRsp;
    logic clearRsp;
    logic popRsp;
  } rspStrobe_t;
endpackage

// File: rtl/mmcRspFifo.sv
module mmcRspFifo
  import mmcCmdPkg::*;
#(
  parameter int ENTRIES = 9,
  parameter int ENTRY_W = 16,
  parameter int BYTES   = 16,
  parameter int LEN_W   = $clog2(BYTES + 1),
  parameter int PTR_W   = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  rspStrobe_t         strobe,
  input  logic [1:0]         rspType,
  input  logic [LEN_W-1:0]   rspLen,
  input  logic [BYTES*8-1:0] rspData,
  output logic               rspOk,
  output logic [ENTRY_W-1:0] headWord
);
  localparam int BYTES_PER_ENTRY = ENTRY_W / 8;

  logic [ENTRY_W-1:0] entry   [ENTRIES];
  logic [ENTRY_W-1:0] loadVal [ENTRIES];
  logic [PTR_W-1:0]   rdPtr;

  // length check against the latched response type
  always_comb begin
    case (rspType)
      2'd0:    rspOk = 1'b1;
      2'd2:    rspOk = (rspLen >= LEN_W'(BYTES));
      default: rspOk = (rspLen >= LEN_W'(SHORT_RSP_BYTES));
    endcase
  end

  // byte packing: entry g, lane b takes card byte g*BYTES_PER_ENTRY+b
  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    for (genvar b = 0; b < BYTES_PER_ENTRY; b++) begin : gLane
      localparam int IDX = g * BYTES_PER_ENTRY + b;
      if (IDX < BYTES) begin : gLive
        assign loadVal[g][b*8 +: 8] = (LEN_W'(IDX) < rspLen) ? rspData[IDX*8 +: 8] : 8'h00;
      end else begin : gDead
        assign loadVal[g][b*8 +: 8] = 8'h00;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entry[g] <= '0;
      end else if (strobe.loadRsp) begin
        entry[g] <= loadVal[g];
      end else if (strobe.clearRsp) begin
        entry[g] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (strobe.loadRsp || strobe.clearRsp) begin
      rdPtr <= '0;
    end else if (strobe.popRsp && (rdPtr < PTR_W'(ENTRIES))) begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  assign headWord = (rdPtr < PTR_W'(ENTRIES)) ? entry[rdPtr] : '0;

  a_r10_ptr_bounded: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr <= PTR_W'(ENTRIES));

  a_r10_load_rewinds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRsp || strobe.clearRsp) |=> (rdPtr == '0));

  a_r10_exhausted_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr == PTR_W'(ENTRIES)) |-> (headWord == '0));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearRsp |=> (headWord == '0));
endmodule

// File: rtl/mmcCmdCtrl.sv
module mmcCmdCtrl
  import mmcCmdPkg::*;
#(
  parameter int ENTRY_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [REG_DATA_W-1:0] regWrData,
  output logic [REG_DATA_W-1:0] regRdData,
  input  logic                  rspOk,
  input  logic [ENTRY_W-1:0]    headWord,
  output rspStrobe_t            strobe,
  output logic [1:0]            rspType,
  output logic                  cardReq,
  output logic [CMD_IDX_W-1:0]  cardCmd,
  output logic [ARG_W-1:0]      cardArg,
  input  logic                  cardRspValid,
  output logic                  dataStart,
  output logic                  dataWrite
);
  logic [REG_DATA_W-1:0] ctrlReg, ctrlNext;
  logic [CMD_IDX_W-1:0]  cmdIdx;
  logic [ARG_W-1:0]      argReg;
  logic [RSPTO_W-1:0]    rspTo;
  logic [RDTO_W-1:0]     rdTo;
  logic clkEn, pending, busy;
  logic stTimeout, stRspOk, intEndCmd;
  logic lData, lWrite;
  logic wrClk, wrCtrl, startReq, stopReq, launch, complete, goodData;

  wire unusedWrBits = ^regWrData[REG_DATA_W-1:HALF_W];

  assign wrClk    = regWrEn && (regAddr == OFF_CLKCTL);
  assign wrCtrl   = regWrEn && (regAddr == OFF_CTRL);
  assign startReq = wrClk && regWrData[CLK_START_BIT];
  assign stopReq  = wrClk && regWrData[CLK_STOP_BIT];
  assign ctrlNext = wrCtrl ? (regWrData & CTRL_MASK) : ctrlReg;

  assign launch = !busy &&
    ((wrCtrl && clkEn && !regWrData[CTRL_STOP]) ||
     (startReq && !stopReq && pending && !ctrlReg[CTRL_STOP]));
  assign complete = busy && cardRspValid;
  assign goodData = complete && rspOk && lData;

  assign strobe.loadRsp  = complete && rspOk;
  assign strobe.clearRsp = complete && !rspOk;
  assign strobe.popRsp   = regRdEn && (regAddr == OFF_RSPFIFO);
  assign cardReq = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0; cmdIdx <= '0; argReg <= '0; rspTo <= '0; rdTo <= '0;
      clkEn <= 1'b0; pending <= 1'b0; busy <= 1'b0;
      stTimeout <= 1'b0; stRspOk <= 1'b0; intEndCmd <= 1'b0;
      cardCmd <= '0; cardArg <= '0; rspType <= '0; lData <= 1'b0; lWrite <= 1'b0;
      dataStart <= 1'b0; dataWrite <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= regWrData & CTRL_MASK;
      if (regWrEn && regAddr == OFF_CMDIDX) cmdIdx <= regWrData[CMD_IDX_W-1:0];
      if (regWrEn && regAddr == OFF_ARGHI)  argReg[ARG_W-1:HALF_W] <= regWrData[HALF_W-1:0];
      if (regWrEn && regAddr == OFF_ARGLO)  argReg[HALF_W-1:0] <= regWrData[HALF_W-1:0];
      if (regWrEn && regAddr == OFF_RSPTO)  rspTo <= regWrData[RSPTO_W-1:0];
      if (regWrEn && regAddr == OFF_RDTO)   rdTo <= regWrData[RDTO_W-1:0];

      if (startReq) clkEn <= 1'b1;
      if (stopReq)  clkEn <= 1'b0;

      if (launch)      pending <= 1'b0;
      else if (wrCtrl) pending <= 1'b1;

      if (launch) begin
        busy      <= 1'b1;
        cardCmd   <= cmdIdx;
        cardArg   <= argReg;
        rspType   <= ctrlNext[1:0];
        lData     <= ctrlNext[CTRL_DATA_EN];
        lWrite    <= ctrlNext[CTRL_WRITE];
        stTimeout <= 1'b0;
        stRspOk   <= 1'b0;
      end else if (complete) begin
        busy      <= 1'b0;
        stTimeout <= !rspOk;
        stRspOk   <= rspOk;
        intEndCmd <= 1'b1;
      end

      dataStart <= goodData;
      if (goodData) dataWrite <= lWrite;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFF_STATUS: begin
        regRdData[STAT_TOUT]  = stTimeout;
        regRdData[STAT_CLKON] = clkEn;
        regRdData[STAT_RSPOK] = stRspOk;
      end
      OFF_CTRL:    regRdData = ctrlReg;
      OFF_RSPTO:   regRdData = REG_DATA_W'(rspTo);
      OFF_RDTO:    regRdData = REG_DATA_W'(rdTo);
      OFF_INTREQ:  regRdData[INT_ENDCMD] = intEndCmd;
      OFF_CMDIDX: begin
        regRdData = REG_DATA_W'(cmdIdx);
        regRdData[CMD_READ_FLAG] = 1'b1;
      end
      OFF_ARGHI:   regRdData = REG_DATA_W'(argReg[ARG_W-1:HALF_W]);
      OFF_ARGLO:   regRdData = REG_DATA_W'(argReg[HALF_W-1:0]);
      OFF_RSPFIFO: regRdData = REG_DATA_W'(headWord);
      default:     regRdData = '0;
    endcase
  end

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (cardReq && !cardRspValid) |=> cardReq);

  a_r6_cmd_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cardReq && !cardRspValid) |=> ($stable(cardCmd) && $stable(cardArg)));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stTimeout && stRspOk));

  a_r8_endcmd_set: assert property (@(posedge clk) disable iff (!rstN)
    (cardReq && cardRspValid) |=> intEndCmd);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataStart |=> !dataStart);

  a_r2_stop_wins: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !clkEn);
endmodule

// File: rtl/mmcCmdPath.sv
module mmcCmdPath
  import mmcCmdPkg::*;
#(
  parameter int RSP_ENTRIES = 9,
  parameter int ENTRY_W     = 16,
  parameter int RSP_BYTES   = 16,
  localparam int LEN_W      = $clog2(RSP_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [REG_DATA_W-1:0] regWrData,
  output logic [REG_DATA_W-1:0] regRdData,
  output logic                  cardReq,
  output logic [CMD_IDX_W-1:0]  cardCmd,
  output logic [ARG_W-1:0]      cardArg,
  input  logic                  cardRspValid,
  input  logic [LEN_W-1:0]      cardRspLen,
  input  logic [RSP_BYTES*8-1:0] cardRspData,
  output logic                  dataStart,
  output logic                  dataWrite
);
  rspStrobe_t         strobe;
  logic [1:0]         rspType;
  logic               rspOk;
  logic [ENTRY_W-1:0] headWord;

  mmcCmdCtrl #(.ENTRY_W(ENTRY_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rspOk(rspOk), .headWord(headWord), .strobe(strobe), .rspType(rspType),
    .cardReq(cardReq), .cardCmd(cardCmd), .cardArg(cardArg),
    .cardRspValid(cardRspValid), .dataStart(dataStart), .dataWrite(dataWrite)
  );

  mmcRspFifo #(
    .ENTRIES(RSP_ENTRIES), .ENTRY_W(ENTRY_W), .BYTES(RSP_BYTES), .LEN_W(LEN_W)
  ) uFifo (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rspType(rspType),
    .rspLen(cardRspLen), .rspData(cardRspData), .rspOk(rspOk), .headWord(headWord)
  );
endmodule

// File: tb/mmcCmdPath_test.sv
module mmcCmdPath_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [6:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic cardReq;
  logic [5:0] cardCmd;
  logic [31:0] cardArg;
  logic cardRspValid = 1'b0;
  logic [4:0] cardRspLen = '0;
  logic [127:0] cardRspData = '0;
  logic dataStart, dataWrite;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model state
  bit mClk, mPend, mBusy, mStart;
  int mCtl, mType, mData;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmcCmdPath uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cardReq(cardReq), .cardCmd(cardCmd), .cardArg(cardArg),
    .cardRspValid(cardRspValid), .cardRspLen(cardRspLen), .cardRspData(cardRspData),
    .dataStart(dataStart), .dataWrite(dataWrite)
  );

  function automatic bit lenGood(int typ, int len);
    if (typ == 0) return 1;
    if (typ == 2) return len >= 16;
    return len >= 4;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mClk = 0; mPend = 0; mBusy = 0; mStart = 0; mCtl = 0; mType = 0; mData = 0;
    end else begin
      bit go;
      go = 0;
      mStart = 0;
      if (regWrEn && regAddr == 7'h00) begin
        if (regWrData[1] && !regWrData[0] && mPend && !mCtl[10] && !mBusy) go = 1;
        if (regWrData[1]) mClk = 1;
        if (regWrData[0]) mClk = 0;
      end
      if (regWrEn && regAddr == 7'h10) begin
        mCtl = int'(regWrData & 32'h3DFF);
        mPend = 1;
        if (mClk && !regWrData[10] && !mBusy) go = 1;
      end
      if (mBusy && cardRspValid) begin
        mBusy = 0;
        if (lenGood(mType, int'(cardRspLen)) && mData != 0) mStart = 1;
      end
      if (go) begin
        mBusy = 1; mPend = 0; mType = mCtl & 3; mData = (mCtl >> 2) & 1;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R4 model cardReq", 32'(cardReq), 32'(mBusy));
      check("R11 model dataStart", 32'(dataStart), 32'(mStart));
    end
  end

  task automatic regWrite(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic regRead(logic [6:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    regRdEn = 1; regAddr = a;
    #1 check(tag, regRdData, exp);
    @(posedge clk); #1;
    regRdEn = 0;
  endtask

  function automatic logic [127:0] bytesFrom(logic [7:0] base);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[k*8 +: 8] = base + 8'(k);
    return v;
  endfunction

  task automatic respond(int len, logic [7:0] base);
    @(negedge clk);
    while (!cardReq) @(negedge clk);
    cardRspValid = 1; cardRspLen = 5'(len); cardRspData = bytesFrom(base);
    @(posedge clk); #1;
    cardRspValid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    check("R1 cardReq", 32'(cardReq), 0);
    check("R1 dataStart", 32'(dataStart), 0);
    regRead(7'h04, 32'h0, "R1 status");
    regRead(7'h2C, 32'h0, "R1 intreq");
    regRead(7'h3C, 32'h0, "R1 fifo");

    // R3 field masks; clock off so nothing launches (R5)
    regWrite(7'h10, 32'hFFFF_FFFF);
    regRead(7'h10, 32'h3DFF, "R3 ctrl mask");
    regWrite(7'h30, 32'hFF);
    regRead(7'h30, 32'h7F, "R3 cmd index");
    regWrite(7'h34, 32'h1234_ABCD);
    regWrite(7'h38, 32'h0000_5678);
    regRead(7'h34, 32'hABCD, "R3 arg high");
    regRead(7'h38, 32'h5678, "R3 arg low");
    regWrite(7'h14, 32'hFF);
    regRead(7'h14, 32'h7F, "R3 response timeout");
    regWrite(7'h18, 32'h12345);
    regRead(7'h18, 32'h2345, "R3 read timeout");

    // R2 / R5 clock control, stop-transfer blocks launch
    regWrite(7'h00, 32'h2);
    check("R5 stop-transfer no launch", 32'(cardReq), 0);
    regRead(7'h04, 32'h100, "R2 clock on");
    regWrite(7'h00, 32'h1);
    regRead(7'h04, 32'h0, "R2 clock off");
    regWrite(7'h00, 32'h3);
    regRead(7'h04, 32'h0, "R2 stop wins");

    // R5 deferred launch
    regWrite(7'h10, 32'h1);
    check("R5 clock off no launch", 32'(cardReq), 0);
    regRead(7'h2C, 32'h0, "R8 no completion yet");
    regWrite(7'h00, 32'h2);
    check("R5 start-clock launches", 32'(cardReq), 1);
    check("R4 command index", 32'(cardCmd), 32'h3F);
    check("R4 argument", cardArg, 32'hABCD_5678);
    respond(6, 8'h11);
    regRead(7'h04, 32'h2100, "R7 good type1");
    regRead(7'h2C, 32'h4, "R8 end of command");
    regRead(7'h3C, 32'h1211, "R9 entry0");
    regRead(7'h3C, 32'h1413, "R9 entry1");
    regRead(7'h3C, 32'h1615, "R9 entry2");
    for (int i = 3; i < 9; i++) regRead(7'h3C, 32'h0, "R9 past byte count");
    regRead(7'h3C, 32'h0, "R10 after nine reads");

    // R4 immediate launch, R7 short type2
    regWrite(7'h10, 32'h2);
    check("R4 immediate launch", 32'(cardReq), 1);
    regRead(7'h04, 32'h100, "R7 launch clears flags");
    respond(8, 8'h11);
    regRead(7'h04, 32'h102, "R7 short type2");
    regRead(7'h3C, 32'h0, "R9 cleared on timeout");
    regWrite(7'h10, 32'h3);
    respond(4, 8'h11);
    regRead(7'h04, 32'h2100, "R7 type3 four bytes");
    regRead(7'h3C, 32'h1211, "R9 type3 entry0");
    regRead(7'h3C, 32'h1413, "R9 type3 entry1");
    regRead(7'h3C, 32'h0, "R9 type3 entry2");
    regWrite(7'h10, 32'h0);
    respond(0, 8'h11);
    regRead(7'h04, 32'h2100, "R7 type0 no bytes");
    regWrite(7'h10, 32'h1);
    respond(3, 8'h11);
    regRead(7'h04, 32'h102, "R7 short type1");

    // R11 data phase start
    regWrite(7'h10, 32'hD);
    respond(4, 8'h11);
    check("R11 start pulse", 32'(dataStart), 1);
    check("R11 write direction", 32'(dataWrite), 1);
    regWrite(7'h10, 32'h5);
    respond(2, 8'h11);
    check("R11 no pulse on timeout", 32'(dataStart), 0);
    regWrite(7'h10, 32'h4);
    respond(0, 8'h11);
    check("R11 type0 pulse", 32'(dataStart), 1);
    check("R11 read direction", 32'(dataWrite), 0);
    regWrite(7'h10, 32'h1);
    respond(4, 8'h11);
    check("R11 no pulse without data enable", 32'(dataStart), 0);

    // R6 refusal while outstanding
    regWrite(7'h30, 32'h05);
    regWrite(7'h10, 32'h1);
    check("R6 first launch index", 32'(cardCmd), 32'h05);
    regWrite(7'h30, 32'h06);
    regWrite(7'h10, 32'h3);
    check("R6 index unchanged while busy", 32'(cardCmd), 32'h05);
    respond(4, 8'h11);
    check("R6 no relaunch after refusal", 32'(cardReq), 0);
    regWrite(7'h00, 32'h2);
    check("R6 pending launches later", 32'(cardReq), 1);
    check("R6 new index", 32'(cardCmd), 32'h06);
    regWrite(7'h10, 32'h1);
    // launch attempt in the completion cycle
    @(negedge clk);
    cardRspValid = 1; cardRspLen = 5'd16; cardRspData = bytesFrom(8'h11);
    regWrEn = 1; regAddr = 7'h00; regWrData = 32'h2;
    @(posedge clk); #1;
    cardRspValid = 0; regWrEn = 0;
    check("R6 refused in completion cycle", 32'(cardReq), 0);
    regRead(7'h04, 32'h2100, "R7 type3 latched at launch");
    regRead(7'h3C, 32'h1211, "R9 full entry0");
    regRead(7'h3C, 32'h1413, "R9 full entry1");
    regWrite(7'h00, 32'h2);
    check("R6 pending survives", 32'(cardReq), 1);
    // pop in the load cycle
    @(negedge clk);
    cardRspValid = 1; cardRspLen = 5'd4; cardRspData = bytesFrom(8'h40);
    regRdEn = 1; regAddr = 7'h3C;
    @(posedge clk); #1;
    cardRspValid = 0; regRdEn = 0;
    regRead(7'h3C, 32'h4140, "R10 load rewinds over pop");
    regRead(7'h3C, 32'h4342, "R10 next after rewind");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule